// File: doc/BRIEF.md
# DMA Channel Transfer Step Sequencer

This block carries out one transfer step for a channel that has already been granted the bus. A `start` strobe captures a snapshot of the channel's programmed state: page, base address, base count, current address, current count and mode fields. The block then checks that the request is legal and forms the physical memory address. It issues one command, chosen by the transfer type, and hands back the stepped address and count. At terminal count it also signals whether the channel must be masked.

The step runs through named states:

- IDLE waits for `start`.
- CHECK evaluates the legality tests on the captured snapshot. CHECK goes to ISSUE when the request is legal and to FAULT when any test fails.
- ISSUE drives the memory address, the acknowledge and exactly one command pulse.
- COMMIT presents the updated register values, `done` and, at terminal count, `tc` and `set_mask`.
- FAULT raises the matching error flags with `done` and issues nothing.

Both COMMIT and FAULT return to IDLE.

Word channels move two bytes per step. Their address is shifted left by one under the page, and their region check covers 128K instead of 64K. Address stepping wraps inside the 16-bit address and never reaches the page.

Top module: `dma_xfer_step`

## Requirements
- R1: After reset the block is idle: `busy`, `dack`, `done`, `tc`, `upd_valid`, all command and error outputs are 0 and `mem_addr` is 0.
- R2: During the ISSUE cycle the physical address depends on the channel width. On a byte channel `mem_addr` is {page, cur_addr}. On a word channel it is (page << 16) OR (cur_addr << 1), and `wide_xfer` is 1.
- R3: The stepped address is cur_addr+1, or cur_addr-1 when `dec_mode` is 1. It wraps modulo 2^16 (0xFFFF+1 = 0x0000, 0x0000-1 = 0xFFFF) and never alters the page.
- R4: The stepped count is cur_count-1. When cur_count is 0 the count becomes 0xFFFF and the step is terminal: `tc` pulses for one cycle together with `dack`, `done` and `upd_valid`.
- R5: On a terminal step with `auto_init` = 1, `new_addr` and `new_count` equal the base address and base count, and `set_mask` stays 0.
- R6: On a terminal step with `auto_init` = 0, `set_mask` is 1 and `new_addr`/`new_count` carry the stepped values.
- R7: Transfer type 1 gives one `cmd_mem_wr` pulse, type 2 one `cmd_mem_rd` pulse and type 0 one `cmd_verify` pulse. Each pulse lasts the single ISSUE cycle, and no other command pulses with it.
- R8: Transfer type 3 sends the step to FAULT with `err_kind` = 1. No command, `dack` or `upd_valid` is produced.
- R9: Operating mode 2 (block) sends the step to FAULT with `err_mode` = 1. Modes 0 (demand), 1 (single) and 3 (cascade) are accepted.
- R10: The region check runs on the base values. The end is computed as start ± (base_count scaled by width), where start = page·2^16 OR (base_addr scaled by width). If start and end differ in the 64K region (byte) or 128K region (word), the step goes to FAULT with `err_region` = 1. This includes a decrement that falls below address 0.
- R11: The step has fixed timing relative to the clock edge that samples `start`:
  - ISSUE follows the second edge after that sample.
  - COMMIT follows the third edge.
  - FAULT follows the second edge.
  - `busy` is 0 again after COMMIT or FAULT.
  - A `start` seen while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one transfer step (captures the channel snapshot) |
| word_chan | input | 1 | 1 = word channel (two-byte transfer) |
| page | input | 8 | Page register (physical bits 23:16) |
| base_addr | input | 16 | Base address register |
| base_count | input | 16 | Base count register |
| cur_addr | input | 16 | Current address register |
| cur_count | input | 16 | Current count register |
| dec_mode | input | 1 | 1 = address steps downward |
| auto_init | input | 1 | 1 = reload from base at terminal count |
| xfer_kind | input | 2 | 0 verify, 1 device to memory, 2 memory to device, 3 illegal |
| op_mode | input | 2 | 0 demand, 1 single, 2 block (rejected), 3 cascade |
| busy | output | 1 | A step is in progress |
| mem_addr | output | 24 | Physical address while `dack` is 1, else 0 |
| wide_xfer | output | 1 | Two-byte transfer while `dack` is 1 |
| dack | output | 1 | Channel acknowledge (ISSUE and COMMIT) |
| cmd_mem_wr | output | 1 | Device-to-memory command pulse |
| cmd_mem_rd | output | 1 | Memory-to-device command pulse |
| cmd_verify | output | 1 | Verify command pulse (device read, no memory write) |
| tc | output | 1 | Terminal count pulse |
| done | output | 1 | Step finished (COMMIT or FAULT) |
| upd_valid | output | 1 | `new_addr`/`new_count`/`set_mask` are valid |
| new_addr | output | 16 | Updated current address |
| new_count | output | 16 | Updated current count |
| set_mask | output | 1 | Channel mask bit must be set |
| err_kind | output | 1 | Illegal transfer type |
| err_mode | output | 1 | Unsupported block mode |
| err_region | output | 1 | Transfer would cross a 64K/128K region |

## Verification
The assertions rely on the channel snapshot captured at `start` staying constant for the whole step, which the capture registers guarantee. They also rely on `start` being honoured only in IDLE. The bench therefore holds the channel fields steady from the `start` pulse until `done`, and raises `start` only on a falling edge. It raises `start` during a busy step only in the one scenario that tests that it is ignored. Each illegal field (type 3, block mode, region crossing) is driven alone in its own scenario, so that exactly one error flag is expected.

// File: rtl/dma_step_pkg.sv
package dma_step_pkg;

    typedef enum logic [1:0] {
        XF_VERIFY   = 2'd0,
        XF_TO_MEM   = 2'd1,
        XF_FROM_MEM = 2'd2,
        XF_ILLEGAL  = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        OP_DEMAND  = 2'd0,
        OP_SINGLE  = 2'd1,
        OP_BLOCK   = 2'd2,
        OP_CASCADE = 2'd3
    } op_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_ISSUE  = 3'd2,
        ST_COMMIT = 3'd3,
        ST_FAULT  = 3'd4
    } step_state_e;

    typedef struct packed {
        logic       word;
        logic       dec;
        logic       autoinit;
        xfer_kind_e kind;
        op_mode_e   mode;
    } chan_cfg_t;

endpackage

// File: rtl/dma_step_addr.sv
module dma_step_addr #(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic [PAGE_W-1:0]        page,
    input  logic [ADDR_W-1:0]        cur_addr,
    input  logic [ADDR_W-1:0]        cur_count,
    input  logic [ADDR_W-1:0]        base_addr,
    input  logic [ADDR_W-1:0]        base_count,
    input  logic                     word,
    input  logic                     dec,
    input  logic                     autoinit,
    output logic [PAGE_W+ADDR_W-1:0] phys_addr,
    output logic [ADDR_W-1:0]        next_addr,
    output logic [ADDR_W-1:0]        next_count,
    output logic                     terminal,
    output logic                     mask_req
);
    localparam int PHYS_W = PAGE_W + ADDR_W;

    logic [PHYS_W-1:0] page_part;
    logic [PHYS_W-1:0] offset_part;
    logic [ADDR_W-1:0] stepped_addr;
    logic [ADDR_W-1:0] stepped_count;

    // Physical address: page above, current address (scaled for words) OR'd in
    always_comb begin
        page_part = {page, {ADDR_W{1'b0}}};
        if (word) begin
            offset_part = {{(PAGE_W-1){1'b0}}, cur_addr, 1'b0};
        end else begin
            offset_part = {{PAGE_W{1'b0}}, cur_addr};
        end
        phys_addr = page_part | offset_part;
    end

    // Stepping stays inside the ADDR_W field; the page is never touched
    always_comb begin
        if (dec) begin
            stepped_addr = cur_addr - {{(ADDR_W-1){1'b0}}, 1'b1};
        end else begin
            stepped_addr = cur_addr + {{(ADDR_W-1){1'b0}}, 1'b1};
        end
        stepped_count = cur_count - {{(ADDR_W-1){1'b0}}, 1'b1};
        terminal      = (cur_count == '0);
    end

    always_comb begin
        if (terminal && autoinit) begin
            next_addr  = base_addr;
            next_count = base_count;
        end else begin
            next_addr  = stepped_addr;
            next_count = stepped_count;
        end
        mask_req = terminal && !autoinit;
    end

endmodule

// File: rtl/dma_step_region.sv
module dma_step_region #(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] base_count,
    input  logic              word,
    input  logic              dec,
    output logic              crosses
);
    // One spare bit on top catches a borrow below zero or a carry past the top
    localparam int EXT_W = PAGE_W + ADDR_W + 1;

    logic [EXT_W-1:0] start_x;
    logic [EXT_W-1:0] span_x;
    logic [EXT_W-1:0] end_x;

    always_comb begin
        if (word) begin
            start_x = {1'b0, page, {ADDR_W{1'b0}}} | {{PAGE_W{1'b0}}, base_addr, 1'b0};
            span_x  = {{PAGE_W{1'b0}}, base_count, 1'b0};
        end else begin
            start_x = {1'b0, page, {ADDR_W{1'b0}}} | {{(PAGE_W+1){1'b0}}, base_addr};
            span_x  = {{(PAGE_W+1){1'b0}}, base_count};
        end
        if (dec) begin
            end_x = start_x - span_x;
        end else begin
            end_x = start_x + span_x;
        end
        if (word) begin
            crosses = (start_x[EXT_W-1:ADDR_W+1] != end_x[EXT_W-1:ADDR_W+1]);
        end else begin
            crosses = (start_x[EXT_W-1:ADDR_W] != end_x[EXT_W-1:ADDR_W]);
        end
    end

endmodule

// File: rtl/dma_xfer_step.sv
module dma_xfer_step
    import dma_step_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     word_chan,
    input  logic [PAGE_W-1:0]        page,
    input  logic [ADDR_W-1:0]        base_addr,
    input  logic [ADDR_W-1:0]        base_count,
    input  logic [ADDR_W-1:0]        cur_addr,
    input  logic [ADDR_W-1:0]        cur_count,
    input  logic                     dec_mode,
    input  logic                     auto_init,
    input  logic [1:0]               xfer_kind,
    input  logic [1:0]               op_mode,
    output logic                     busy,
    output logic [PAGE_W+ADDR_W-1:0] mem_addr,
    output logic                     wide_xfer,
    output logic                     dack,
    output logic                     cmd_mem_wr,
    output logic                     cmd_mem_rd,
    output logic                     cmd_verify,
    output logic                     tc,
    output logic                     done,
    output logic                     upd_valid,
    output logic [ADDR_W-1:0]        new_addr,
    output logic [ADDR_W-1:0]        new_count,
    output logic                     set_mask,
    output logic                     err_kind,
    output logic                     err_mode,
    output logic                     err_region
);
    localparam int PHYS_W = PAGE_W + ADDR_W;

    step_state_e state_q, state_d;
    chan_cfg_t   cfg_q;
    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] base_addr_q, base_count_q, cur_addr_q, cur_count_q;

    logic [PHYS_W-1:0] phys_addr;
    logic [ADDR_W-1:0] next_addr, next_count;
    logic              terminal, mask_req, crosses;
    logic              bad_kind, bad_mode, any_fault;

    // Snapshot of the channel, taken only when a step is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            page_q       <= '0;
            base_addr_q  <= '0;
            base_count_q <= '0;
            cur_addr_q   <= '0;
            cur_count_q  <= '0;
        end else if (state_q == ST_IDLE && start) begin
            cfg_q.word     <= word_chan;
            cfg_q.dec      <= dec_mode;
            cfg_q.autoinit <= auto_init;
            cfg_q.kind     <= xfer_kind_e'(xfer_kind);
            cfg_q.mode     <= op_mode_e'(op_mode);
            page_q         <= page;
            base_addr_q    <= base_addr;
            base_count_q   <= base_count;
            cur_addr_q     <= cur_addr;
            cur_count_q    <= cur_count;
        end
    end

    dma_step_addr #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) addr_i (
        .page       (page_q),
        .cur_addr   (cur_addr_q),
        .cur_count  (cur_count_q),
        .base_addr  (base_addr_q),
        .base_count (base_count_q),
        .word       (cfg_q.word),
        .dec        (cfg_q.dec),
        .autoinit   (cfg_q.autoinit),
        .phys_addr  (phys_addr),
        .next_addr  (next_addr),
        .next_count (next_count),
        .terminal   (terminal),
        .mask_req   (mask_req)
    );

    dma_step_region #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) region_i (
        .page       (page_q),
        .base_addr  (base_addr_q),
        .base_count (base_count_q),
        .word       (cfg_q.word),
        .dec        (cfg_q.dec),
        .crosses    (crosses)
    );

    always_comb begin
        bad_kind  = (cfg_q.kind == XF_ILLEGAL);
        bad_mode  = (cfg_q.mode == OP_BLOCK);
        any_fault = bad_kind || bad_mode || crosses;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CHECK;
            ST_CHECK:  state_d = any_fault ? ST_FAULT : ST_ISSUE;
            ST_ISSUE:  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy       = 1'b0;
        mem_addr   = '0;
        wide_xfer  = 1'b0;
        dack       = 1'b0;
        cmd_mem_wr = 1'b0;
        cmd_mem_rd = 1'b0;
        cmd_verify = 1'b0;
        tc         = 1'b0;
        done       = 1'b0;
        upd_valid  = 1'b0;
        new_addr   = '0;
        new_count  = '0;
        set_mask   = 1'b0;
        err_kind   = 1'b0;
        err_mode   = 1'b0;
        err_region = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_CHECK: begin
                busy = 1'b1;
            end
            ST_ISSUE: begin
                busy       = 1'b1;
                dack       = 1'b1;
                mem_addr   = phys_addr;
                wide_xfer  = cfg_q.word;
                cmd_mem_wr = (cfg_q.kind == XF_TO_MEM);
                cmd_mem_rd = (cfg_q.kind == XF_FROM_MEM);
                cmd_verify = (cfg_q.kind == XF_VERIFY);
            end
            ST_COMMIT: begin
                busy      = 1'b1;
                dack      = 1'b1;
                mem_addr  = phys_addr;
                wide_xfer = cfg_q.word;
                done      = 1'b1;
                upd_valid = 1'b1;
                tc        = terminal;
                new_addr  = next_addr;
                new_count = next_count;
                set_mask  = mask_req;
            end
            ST_FAULT: begin
                busy       = 1'b1;
                done       = 1'b1;
                err_kind   = bad_kind;
                err_mode   = bad_mode;
                err_region = crosses;
            end
            default: begin
            end
        endcase
    end

    // R4
    tc_with_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (dack && done && upd_valid));

    // R6
    mask_only_at_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_mask |-> tc);

    // R7
    single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_mem_wr, cmd_mem_rd, cmd_verify}));

    // R7
    cmd_then_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mem_wr || cmd_mem_rd || cmd_verify) |=> (upd_valid && dack && done));

    // R8
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_kind || err_mode || err_region) |-> (done && !dack && !upd_valid));

    // R11
    done_ends_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: tb/dma_xfer_step_tb_top.sv
module dma_xfer_step_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        word_chan = 1'b0;
    logic [7:0]  page = '0;
    logic [15:0] base_addr = '0, base_count = '0, cur_addr = '0, cur_count = '0;
    logic        dec_mode = 1'b0, auto_init = 1'b0;
    logic [1:0]  xfer_kind = 2'd1, op_mode = 2'd1;
    logic        busy, wide_xfer, dack, cmd_mem_wr, cmd_mem_rd, cmd_verify;
    logic        tc, done, upd_valid, set_mask, err_kind, err_mode, err_region;
    logic [23:0] mem_addr;
    logic [15:0] new_addr, new_count;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xfer_step dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .word_chan(word_chan),
        .page(page), .base_addr(base_addr), .base_count(base_count),
        .cur_addr(cur_addr), .cur_count(cur_count), .dec_mode(dec_mode),
        .auto_init(auto_init), .xfer_kind(xfer_kind), .op_mode(op_mode),
        .busy(busy), .mem_addr(mem_addr), .wide_xfer(wide_xfer), .dack(dack),
        .cmd_mem_wr(cmd_mem_wr), .cmd_mem_rd(cmd_mem_rd), .cmd_verify(cmd_verify),
        .tc(tc), .done(done), .upd_valid(upd_valid), .new_addr(new_addr),
        .new_count(new_count), .set_mask(set_mask), .err_kind(err_kind),
        .err_mode(err_mode), .err_region(err_region)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic setup(input logic [7:0] pg, input logic [15:0] ba, input logic [15:0] bc,
                         input logic [15:0] ca, input logic [15:0] cc, input logic w,
                         input logic d, input logic ai, input logic [1:0] k, input logic [1:0] m);
        page = pg; base_addr = ba; base_count = bc; cur_addr = ca; cur_count = cc;
        word_chan = w; dec_mode = d; auto_init = ai; xfer_kind = k; op_mode = m;
    endtask

    // start is sampled at edge n; returns at the falling edge after it (CHECK)
    task automatic kick();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic good_step(input string tag, input logic [23:0] e_addr, input logic [2:0] e_cmd,
                             input logic [15:0] e_na, input logic [15:0] e_nc,
                             input logic e_tc, input logic e_mask);
        kick();
        @(negedge clk);  // ISSUE
        chk({tag, " R2 mem_addr"}, mem_addr, e_addr);
        chk({tag, " R7 cmd"}, {cmd_mem_wr, cmd_mem_rd, cmd_verify}, e_cmd);
        chk({tag, " R11 issue dack/done"}, {dack, done, upd_valid}, 3'b100);
        chk({tag, " R2 wide"}, wide_xfer, word_chan);
        @(negedge clk);  // COMMIT
        chk({tag, " R11 commit"}, {dack, done, upd_valid}, 3'b111);
        chk({tag, " R7 no cmd in commit"}, {cmd_mem_wr, cmd_mem_rd, cmd_verify}, 3'b000);
        chk({tag, " R3 new_addr"}, new_addr, e_na);
        chk({tag, " R4 new_count"}, new_count, e_nc);
        chk({tag, " R4 tc"}, tc, e_tc);
        chk({tag, " R6 set_mask"}, set_mask, e_mask);
        @(negedge clk);
        chk({tag, " R11 idle after"}, {busy, dack, done}, 3'b000);
    endtask

    task automatic bad_step(input string tag, input logic [2:0] e_err);
        kick();
        @(negedge clk);  // FAULT
        chk({tag, " R11 fault done"}, {done, dack, upd_valid}, 3'b100);
        chk({tag, " errors"}, {err_kind, err_mode, err_region}, e_err);
        chk({tag, " R8 no cmd"}, {cmd_mem_wr, cmd_mem_rd, cmd_verify}, 3'b000);
        @(negedge clk);
        chk({tag, " R11 idle after fault"}, busy, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", {busy, dack, done, tc, upd_valid, cmd_mem_wr, cmd_mem_rd,
            cmd_verify, err_kind, err_mode, err_region, set_mask}, 12'h000);
        chk("R1 reset mem_addr", mem_addr, 24'h0);
    endtask

    task automatic t_byte_inc();
        setup(8'h12, 16'h3400, 16'h0002, 16'h3400, 16'h0002, 0, 0, 0, 2'd1, 2'd1);
        good_step("byte inc", 24'h123400, 3'b100, 16'h3401, 16'h0001, 0, 0);
    endtask

    task automatic t_word_read();
        setup(8'h20, 16'h8000, 16'h0010, 16'h8001, 16'h0005, 1, 0, 0, 2'd2, 2'd0);
        good_step("word R2", 24'h210002, 3'b010, 16'h8002, 16'h0004, 0, 0);
    endtask

    task automatic t_dec_wrap();
        setup(8'h05, 16'h0010, 16'h0005, 16'h0000, 16'h0003, 0, 1, 0, 2'd0, 2'd3);
        good_step("dec wrap R3 cascade R9", 24'h050000, 3'b001, 16'hFFFF, 16'h0002, 0, 0);
    endtask

    task automatic t_inc_wrap();
        setup(8'h07, 16'h0000, 16'h0000, 16'hFFFF, 16'h0009, 0, 0, 0, 2'd1, 2'd0);
        good_step("inc wrap R3", 24'h07FFFF, 3'b100, 16'h0000, 16'h0008, 0, 0);
    endtask

    task automatic t_tc_mask();
        setup(8'h01, 16'h1000, 16'h0004, 16'h1004, 16'h0000, 0, 0, 0, 2'd1, 2'd1);
        good_step("terminal R6", 24'h011004, 3'b100, 16'h1005, 16'hFFFF, 1, 1);
    endtask

    task automatic t_tc_reload();
        setup(8'h02, 16'h4000, 16'h0100, 16'h4100, 16'h0000, 0, 0, 1, 2'd2, 2'd1);
        good_step("autoinit R5", 24'h024100, 3'b010, 16'h4000, 16'h0100, 1, 0);
    endtask

    task automatic t_word_128k_ok();
        setup(8'h00, 16'h7FF0, 16'h0020, 16'h7FF0, 16'h0001, 1, 0, 0, 2'd0, 2'd1);
        good_step("word 128K R10", 24'h00FFE0, 3'b001, 16'h7FF1, 16'h0000, 0, 0);
    endtask

    task automatic t_faults();
        setup(8'h03, 16'h0000, 16'h0001, 16'h0000, 16'h0001, 0, 0, 0, 2'd3, 2'd1);
        bad_step("type3 R8", 3'b100);
        setup(8'h03, 16'h0000, 16'h0001, 16'h0000, 16'h0001, 0, 0, 0, 2'd1, 2'd2);
        bad_step("block R9", 3'b010);
        setup(8'h01, 16'hFFF0, 16'h0020, 16'hFFF0, 16'h0001, 0, 0, 0, 2'd1, 2'd1);
        bad_step("byte cross R10", 3'b001);
        setup(8'h00, 16'hFFF0, 16'h0020, 16'hFFF0, 16'h0001, 1, 0, 0, 2'd1, 2'd1);
        bad_step("word cross R10", 3'b001);
        setup(8'h00, 16'h0005, 16'h0010, 16'h0005, 16'h0001, 0, 1, 0, 2'd1, 2'd1);
        bad_step("dec underflow R10", 3'b001);
    endtask

    task automatic t_busy_ignore();
        setup(8'h09, 16'h0100, 16'h0004, 16'h0100, 16'h0004, 0, 0, 0, 2'd1, 2'd1);
        kick();
        @(negedge clk) start = 1'b1;  // ISSUE, start sampled while busy
        @(negedge clk) start = 1'b0;  // COMMIT
        chk("R11 commit despite start", done, 1'b1);
        @(negedge clk);
        chk("R11 start while busy ignored", busy, 1'b0);
        @(negedge clk);
        chk("R11 still idle", {busy, dack}, 2'b00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL R11 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_byte_inc();
        t_word_read();
        t_dec_wrap();
        t_inc_wrap();
        t_tc_mask();
        t_tc_reload();
        t_word_128k_ok();
        t_faults();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule